// File: doc/BRIEF.md
# Crypto Controller Interrupt Status and Mask Unit

This unit collects interrupt events from a multi-channel crypto controller and folds them into a single interrupt line. It watches three kinds of events. Each channel reports a completion and a fault. An address checker on the public-key engine's register window adds one more: any access to an offset that reaches no real register or memory. Every event sets its own sticky bit in a status word. Software clears a bit by writing a one to it.

A mask word holds one bit per source; a set bit hides that source from the interrupt line. After reset the individual masks are all clear. The top bit of the mask word is a master enable, and it resets to off. Software can therefore choose its masks before anything can reach the line, and then turn the line on. Software reaches both words through a plain write strobe with a combinational read-back port.

Top module: `crypto_irq_ctrl`

## Requirements
- R1: After reset the status word reads 0, the mask word reads 0 (every source unmasked, master enable off) and `irq_o` is low.
- R2: The master enable is bit 63 of the mask word (register offset 0x8). It is written and read back there.
- R3: While the master enable is 0, `irq_o` stays low whatever the status and masks hold.
- R4: With the master enable at 1, `irq_o` is high exactly when some status bit is set and its mask bit is 0.
- R5: A done pulse on channel i sets status bit i. An error pulse on channel i sets status bit NUM_CH+i. Status is at register offset 0x0, and the bit shows one clock after the pulse.
- R6: A status bit that is set stays set until software clears it.
- R7: Writing the status word clears each bit that is written as 1 and leaves each bit written as 0 unchanged.
- R8: If a set event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R9: An access strobe on the public-key window at an offset outside every mapped range sets status bit 2*NUM_CH. The mapped ranges are 0x000-0x01F, 0x040-0x047, 0x200-0x3FF and 0x400-0x4FF.
- R10: An access to any offset inside a mapped range, including the first and last offset of each range, never sets the address-error bit. An offset presented without the access strobe does not set it either.
- R11: Mask bit 2*NUM_CH hides the address-error source from `irq_o`. The status bit is still recorded, and clearing the mask bit raises the line.
- R12: Only mask bits 0..2*NUM_CH and bit 63 hold data. All other mask bits read back as 0 even after a write of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_done_i | input | NUM_CH | Per-channel completion pulses |
| ch_err_i | input | NUM_CH | Per-channel fault pulses |
| pk_acc_i | input | 1 | Strobe: an access to the public-key window is under way |
| pk_addr_i | input | PK_AW | Offset of that access within the window |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register offset (0x0 status, 0x8 mask) |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data, combinational on `reg_addr_i` |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The assertions take for granted that reset is asserted from time zero and that inputs carry no unknown values after reset. They also assume that the public-key offset fits in PK_AW bits and that NUM_CH is small enough for every source bit to sit below bit 63. The bench drives every input on the falling clock edge to known values and holds event pulses for exactly one cycle. It keeps offsets within 12 bits and uses the default four channels, so the status layout it expects is fixed at done 0-3, error 4-7 and address error 8.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Register file geometry
    localparam int DW       = 64;
    localparam int REG_AW   = 4;
    localparam int GIE_BIT  = 63;
    localparam logic [REG_AW-1:0] OFS_STATUS = 4'h0;
    localparam logic [REG_AW-1:0] OFS_MASK   = 4'h8;

    // Public-key window map: inclusive offset ranges that decode to real storage
    localparam int MAP_W = 16;
    typedef struct packed {
        logic [MAP_W-1:0] lo;
        logic [MAP_W-1:0] hi;
    } pk_range_t;

    localparam int PK_NRANGE = 4;
    localparam pk_range_t PK_MAP [PK_NRANGE] = '{
        '{lo: 16'h0000, hi: 16'h001F},
        '{lo: 16'h0040, hi: 16'h0047},
        '{lo: 16'h0200, hi: 16'h03FF},
        '{lo: 16'h0400, hi: 16'h04FF}
    };

    // Source layout helpers
    function automatic int src_count(input int nch);
        return 2 * nch + 1;
    endfunction

endpackage

// File: rtl/pk_hole_detect.sv
module pk_hole_detect
    import irq_pkg::*;
#(
    parameter int PK_AW = 12
) (
    input  logic             acc_i,
    input  logic [PK_AW-1:0] addr_i,
    output logic             hole_o
);
    localparam int PAD = MAP_W - PK_AW;

    logic [MAP_W-1:0]     addr_ext;
    logic [PK_NRANGE-1:0] hit;

    assign addr_ext = {{PAD{1'b0}}, addr_i};

    for (genvar g = 0; g < PK_NRANGE; g++) begin : g_range
        assign hit[g] = (addr_ext >= PK_MAP[g].lo) && (addr_ext <= PK_MAP[g].hi);
    end

    assign hole_o = acc_i && (hit == '0);

    // R10: the first offset of the first mapped range is never a hole
    always_comb begin
        if (acc_i && addr_i == '0)
            a_r10_origin_mapped: assert (!hole_o);
    end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int NSRC = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] status_o
);
    logic [NSRC-1:0] status_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                status_q[i] <= 1'b0;
            else if (set_i[i])
                status_q[i] <= 1'b1;
            else if (clr_i[i])
                status_q[i] <= 1'b0;
        end
    end

    assign status_o = status_q;

    // R8: every bit that saw a set event is 1 on the next cycle, even under a clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));

    // R6: without a clear, no set bit falls
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (clr_i == '0) |=> ((status_q & $past(status_q)) == $past(status_q)));

endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate #(
    parameter int NSRC = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_i,
    input  logic [NSRC-1:0] mask_wdata_i,
    input  logic            gie_wdata_i,
    input  logic [NSRC-1:0] status_i,
    output logic [NSRC-1:0] mask_o,
    output logic            gie_o,
    output logic            irq_o
);
    logic [NSRC-1:0] mask_q;
    logic            gie_q;
    logic [NSRC-1:0] live;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            gie_q  <= 1'b0;
        end else if (wr_i) begin
            mask_q <= mask_wdata_i;
            gie_q  <= gie_wdata_i;
        end
    end

    assign live   = status_i & ~mask_q;
    assign irq_o  = gie_q && (live != '0);
    assign mask_o = mask_q;
    assign gie_o  = gie_q;

    // R2: master enable only moves on a mask write
    a_r2_gie_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(gie_q));

    // R1: leaving reset, masks are open and the master enable is off
    a_r1_mask_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '0 && !gie_q));

endmodule

// File: rtl/crypto_irq_ctrl.sv
module crypto_irq_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int PK_AW  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ch_done_i,
    input  logic [NUM_CH-1:0] ch_err_i,
    input  logic              pk_acc_i,
    input  logic [PK_AW-1:0]  pk_addr_i,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [DW-1:0]     reg_wdata_i,
    output logic [DW-1:0]     reg_rdata_o,
    output logic              irq_o
);
    localparam int NSRC   = src_count(NUM_CH);
    localparam int PK_BIT = 2 * NUM_CH;

    logic            hole;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] status;
    logic [NSRC-1:0] mask;
    logic            gie;
    logic            irq;
    logic            wr_status;
    logic            wr_mask;

    pk_hole_detect #(.PK_AW(PK_AW)) u_hole (
        .acc_i  (pk_acc_i),
        .addr_i (pk_addr_i),
        .hole_o (hole)
    );

    assign set_vec   = {hole, ch_err_i, ch_done_i};
    assign wr_status = reg_wr_i && (reg_addr_i == OFS_STATUS);
    assign wr_mask   = reg_wr_i && (reg_addr_i == OFS_MASK);
    assign clr_vec   = wr_status ? reg_wdata_i[NSRC-1:0] : '0;

    irq_status_bank #(.NSRC(NSRC)) u_status (
        .clk      (clk),
        .rst      (rst),
        .set_i    (set_vec),
        .clr_i    (clr_vec),
        .status_o (status)
    );

    irq_mask_gate #(.NSRC(NSRC)) u_mask (
        .clk          (clk),
        .rst          (rst),
        .wr_i         (wr_mask),
        .mask_wdata_i (reg_wdata_i[NSRC-1:0]),
        .gie_wdata_i  (reg_wdata_i[GIE_BIT]),
        .status_i     (status),
        .mask_o       (mask),
        .gie_o        (gie),
        .irq_o        (irq)
    );

    always_comb begin
        unique case (reg_addr_i)
            OFS_STATUS: reg_rdata_o = {{(DW-NSRC){1'b0}}, status};
            OFS_MASK:   reg_rdata_o = {gie, {(DW-1-NSRC){1'b0}}, mask};
            default:    reg_rdata_o = '0;
        endcase
    end

    assign irq_o = irq;

    // R1: status empty and line quiet on the first cycle out of reset
    a_r1_status_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status == '0 && !irq_o));

    // R3: master enable off keeps the line low
    a_r3_gie_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !gie |-> !irq_o);

    // R9: a hole access is recorded on the next cycle
    a_r9_hole_recorded: assert property (@(posedge clk) disable iff (rst)
        hole |=> status[PK_BIT]);

    // R10: an access inside the first mapped range leaves a clear error bit clear
    a_r10_mapped_silent: assert property (@(posedge clk) disable iff (rst)
        (pk_acc_i && ({{(MAP_W-PK_AW){1'b0}}, pk_addr_i} <= 16'h001F) && !status[PK_BIT])
        |=> !status[PK_BIT]);

    // R11: masked address error never drives the line on its own
    a_r11_pk_masked: assert property (@(posedge clk) disable iff (rst)
        (mask[PK_BIT] && ((status & ~mask) == '0)) |-> !irq_o);

endmodule

// File: tb/tb_crypto_irq_ctrl.sv
module tb_crypto_irq_ctrl;

    localparam int NUM_CH = 4;
    localparam int PK_AW  = 12;
    localparam int NVEC   = 15;

    logic              clk = 1'b0;
    logic              rst;
    logic [NUM_CH-1:0] ch_done_i;
    logic [NUM_CH-1:0] ch_err_i;
    logic              pk_acc_i;
    logic [PK_AW-1:0]  pk_addr_i;
    logic              reg_wr_i;
    logic [3:0]        reg_addr_i;
    logic [63:0]       reg_wdata_i;
    logic [63:0]       reg_rdata_o;
    logic              irq_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    crypto_irq_ctrl #(.NUM_CH(NUM_CH), .PK_AW(PK_AW)) dut (
        .clk         (clk),
        .rst         (rst),
        .ch_done_i   (ch_done_i),
        .ch_err_i    (ch_err_i),
        .pk_acc_i    (pk_acc_i),
        .pk_addr_i   (pk_addr_i),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o)
    );

    // {strobe, expected error bit, offset}
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 12'h000}, {1'b1, 1'b0, 12'h01F}, {1'b1, 1'b1, 12'h020},
        {1'b1, 1'b1, 12'h03F}, {1'b1, 1'b0, 12'h040}, {1'b1, 1'b0, 12'h047},
        {1'b1, 1'b1, 12'h048}, {1'b1, 1'b1, 12'h1FF}, {1'b1, 1'b0, 12'h200},
        {1'b1, 1'b0, 12'h3FF}, {1'b1, 1'b0, 12'h400}, {1'b1, 1'b0, 12'h4FF},
        {1'b1, 1'b1, 12'h500}, {1'b1, 1'b1, 12'hFFF}, {1'b0, 1'b0, 12'h020}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [63:0] d);
        reg_wr_i    = 1'b1;
        reg_addr_i  = a;
        reg_wdata_i = d;
        step();
        reg_wr_i    = 1'b0;
        reg_wdata_i = '0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [63:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        logic [63:0] rd;
        rst = 1'b1;
        ch_done_i = '0; ch_err_i = '0; pk_acc_i = 1'b0; pk_addr_i = '0;
        reg_wr_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_read(4'h0, rd); check("R1 status", rd, 64'h0);
        reg_read(4'h8, rd); check("R1 mask", rd, 64'h0);
        check("R1 irq", {63'b0, irq_o}, 64'h0);

        // R9/R10 table walk over the public-key map
        for (int v = 0; v < NVEC; v++) begin
            reg_write(4'h0, '1);
            pk_acc_i  = VEC[v][13];
            pk_addr_i = VEC[v][11:0];
            step();
            pk_acc_i  = 1'b0;
            reg_read(4'h0, rd);
            check(VEC[v][12] ? "R9 hole" : "R10 mapped", {63'b0, rd[8]}, {63'b0, VEC[v][12]});
        end
        reg_write(4'h0, '1);

        // R5 done and error land in separate bits
        ch_done_i = 4'b0100; step(); ch_done_i = '0;
        reg_read(4'h0, rd); check("R5 done ch2", rd, 64'h004);
        ch_err_i = 4'b0100; step(); ch_err_i = '0;
        reg_read(4'h0, rd); check("R5 err ch2", rd, 64'h044);

        // R3 enable off keeps line low
        check("R3 irq gated", {63'b0, irq_o}, 64'h0);

        // R6 sticky
        repeat (5) step();
        reg_read(4'h0, rd); check("R6 sticky", rd, 64'h044);

        // R7 write-one-to-clear
        reg_write(4'h0, 64'h004);
        reg_read(4'h0, rd); check("R7 w1c", rd, 64'h040);

        // R2 / R4 enable and per-source mask
        reg_write(4'h8, 64'h8000_0000_0000_0000);
        reg_read(4'h8, rd); check("R2 gie bit63", rd, 64'h8000_0000_0000_0000);
        check("R4 irq on", {63'b0, irq_o}, 64'h1);
        reg_write(4'h8, 64'h8000_0000_0000_0040);
        check("R4 irq masked", {63'b0, irq_o}, 64'h0);

        // R12 unused mask bits read zero
        reg_write(4'h8, '1);
        reg_read(4'h8, rd); check("R12 mask width", rd, 64'h8000_0000_0000_01FF);

        // R8 set beats clear
        reg_wr_i = 1'b1; reg_addr_i = 4'h0; reg_wdata_i = '1; ch_done_i = 4'b0010;
        step();
        reg_wr_i = 1'b0; reg_wdata_i = '0; ch_done_i = '0;
        reg_read(4'h0, rd); check("R8 set wins", rd, 64'h002);

        // R11 address error masked, still recorded
        reg_write(4'h0, '1);
        reg_write(4'h8, 64'h8000_0000_0000_0100);
        pk_acc_i = 1'b1; pk_addr_i = 12'h030; step(); pk_acc_i = 1'b0;
        reg_read(4'h0, rd); check("R11 recorded", rd, 64'h100);
        check("R11 irq masked", {63'b0, irq_o}, 64'h0);
        reg_write(4'h8, 64'h8000_0000_0000_0000);
        check("R11 irq unmasked", {63'b0, irq_o}, 64'h1);

        // R3 disabling the master enable drops the line
        reg_write(4'h8, 64'h0);
        check("R3 irq off", {63'b0, irq_o}, 64'h0);

        report();
    end

endmodule